// File: doc/BRIEF.md
# ATA PIO Register Access Engine

This block carries out one 16-bit register transfer at a time on a storage card attached in true-IDE mode. A client presents a request made of a 5-bit register select (both chip-enable lines plus the three address bits), a 16-bit write word and a direction flag. The engine then drives the register-select lines, the active-low read and write strobes, and the data-bus output enable. When the transfer is finished it returns a one-cycle done pulse and, for a read, the captured word.

Every bus phase is counted in clock cycles and set by parameters. There is a setup phase with the select lines stable, an active phase with the strobe held low, and a release sequence. That sequence returns the select lines to idle and then, for writes only, removes the output drivers after a hold delay and waits a recovery delay. The defaults give at least 70 ns of setup and at least 165 ns of strobe width at 50 MHz. Command sequencing and status decoding belong to the client.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset the select output is 5'b11000 (chip enables high, address zero), both strobes are high, the output enable, busy and done are low, and the read-data output is zero.
- R2: A request (req_valid high) is taken on a clock edge only when busy is low, and busy goes high after that edge. A request presented while busy is high has no effect on the select, strobes, data or the transfer in progress.
- R3: From the edge that takes a request, the select output carries the requested code for exactly SETUP_CYC cycles before a strobe falls, and it stays unchanged while the strobe is low.
- R4: The strobe that matches the direction (write strobe for req_write=1, read strobe for req_write=0) is low for exactly ACTIVE_CYC cycles. The other strobe stays high, and both are never low together.
- R5: On a write, the output enable rises on the edge that takes the request, the data output carries the request word while the enable is high, and the enable falls HOLD_CYC cycles after the select returns to idle.
- R6: On a read, the output enable stays low throughout, and the read-data output takes the value on the card data input in the last cycle of the low strobe.
- R7: The select output returns to 5'b11000 exactly one cycle after the strobe rises.
- R8: Done is high for exactly one cycle, and busy falls in that same cycle. For a read this is the cycle in which the select returns to idle. For a write it is RECOVER_CYC cycles after the output enable falls.
- R9: A write transfer leaves the read-data output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request, taken when busy is low |
| req_write | input | 1 | 1 for a register write, 0 for a read |
| req_sel | input | 5 | {CE1_n, CE0_n, A2, A1, A0} of the target register |
| req_wdata | input | DATA_W | Word to write |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word captured by the last read |
| ata_sel | output | 5 | Chip-enable and address lines to the card |
| ata_iowr_n | output | 1 | Active-low write strobe |
| ata_iord_n | output | 1 | Active-low read strobe |
| ata_dout | output | DATA_W | Data driven toward the card |
| ata_dout_en | output | 1 | Enable for the data-bus output drivers |
| ata_din | input | DATA_W | Data returned by the card |

## Verification
The assertions assume that reset is held from time zero until the first edges have passed, that every timing parameter is at least one, and that a client keeps req_valid and its fields steady across the edge where it wants them taken. The bench drives all inputs on the falling clock edge and issues reads and writes to both task-file and control codes, including back-to-back requests held high through a done pulse. It also pulses a conflicting request in the middle of a transfer to show it is ignored. Its card model returns a fresh pattern only while the read strobe is low, so a capture taken on the wrong cycle yields a wrong word.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int SEL_W = 5;
  localparam logic [SEL_W-1:0] SEL_IDLE = 5'b11000;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_RELEASE,
    PH_HOLD,
    PH_RECOVER
  } phase_e;

  function automatic int phase_cnt_w(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/ata_pio_timer.sv
module ata_pio_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int SETUP_CYC   = 6,
  parameter int ACTIVE_CYC  = 12,
  parameter int HOLD_CYC    = 6,
  parameter int RECOVER_CYC = 6,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             is_wr,
  output logic             accept,
  output logic             strobe_on,
  output logic             strobe_off,
  output logic             sel_rel,
  output logic             oe_rel,
  output logic             finish
);

  localparam logic [CNT_W-1:0] SETUP_LD   = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] ACTIVE_LD  = CNT_W'(ACTIVE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD    = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RECOVER_LD = CNT_W'(RECOVER_CYC - 1);

  phase_e ph_q, ph_d;
  logic   wr_q;

  always_comb begin
    ph_d       = ph_q;
    timer_load = 1'b0;
    timer_val  = '0;
    accept     = 1'b0;
    strobe_on  = 1'b0;
    strobe_off = 1'b0;
    sel_rel    = 1'b0;
    oe_rel     = 1'b0;
    finish     = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept     = 1'b1;
          timer_load = 1'b1;
          timer_val  = SETUP_LD;
          ph_d       = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (expired) begin
          strobe_on  = 1'b1;
          timer_load = 1'b1;
          timer_val  = ACTIVE_LD;
          ph_d       = PH_ACTIVE;
        end
      end
      PH_ACTIVE: begin
        if (expired) begin
          strobe_off = 1'b1;
          ph_d       = PH_RELEASE;
        end
      end
      PH_RELEASE: begin
        sel_rel = 1'b1;
        if (wr_q) begin
          timer_load = 1'b1;
          timer_val  = HOLD_LD;
          ph_d       = PH_HOLD;
        end else begin
          finish = 1'b1;
          ph_d   = PH_IDLE;
        end
      end
      PH_HOLD: begin
        if (expired) begin
          oe_rel     = 1'b1;
          timer_load = 1'b1;
          timer_val  = RECOVER_LD;
          ph_d       = PH_RECOVER;
        end
      end
      PH_RECOVER: begin
        if (expired) begin
          finish = 1'b1;
          ph_d   = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
      wr_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept) wr_q <= req_write;
    end
  end

  assign is_wr = wr_q;

endmodule

// File: rtl/ata_pio_pins.sv
module ata_pio_pins
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              is_wr,
  input  logic              strobe_on,
  input  logic              strobe_off,
  input  logic              sel_rel,
  input  logic              oe_rel,
  input  logic              finish,
  input  logic [DATA_W-1:0] ata_din,
  output logic [SEL_W-1:0]  ata_sel,
  output logic              ata_iowr_n,
  output logic              ata_iord_n,
  output logic [DATA_W-1:0] ata_dout,
  output logic              ata_dout_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ata_sel     <= SEL_IDLE;
      ata_iowr_n  <= 1'b1;
      ata_iord_n  <= 1'b1;
      ata_dout    <= '0;
      ata_dout_en <= 1'b0;
      rd_data     <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        ata_sel     <= req_sel;
        ata_dout    <= req_wdata;
        ata_dout_en <= req_write;
        busy        <= 1'b1;
      end
      if (strobe_on) begin
        ata_iowr_n <= ~is_wr;
        ata_iord_n <= is_wr;
      end
      if (strobe_off) begin
        ata_iowr_n <= 1'b1;
        ata_iord_n <= 1'b1;
        if (!is_wr) rd_data <= ata_din;
      end
      if (sel_rel) ata_sel <= SEL_IDLE;
      if (oe_rel)  ata_dout_en <= 1'b0;
      if (finish)  busy <= 1'b0;
    end
  end

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SETUP_CYC   = 6,
  parameter int ACTIVE_CYC  = 12,
  parameter int HOLD_CYC    = 6,
  parameter int RECOVER_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [4:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [4:0]        ata_sel,
  output logic              ata_iowr_n,
  output logic              ata_iord_n,
  output logic [DATA_W-1:0] ata_dout,
  output logic              ata_dout_en,
  input  logic [DATA_W-1:0] ata_din
);

  localparam int CNT_W = phase_cnt_w(SETUP_CYC, ACTIVE_CYC, HOLD_CYC, RECOVER_CYC);

  logic             timer_load, expired;
  logic [CNT_W-1:0] timer_val;
  logic             is_wr, accept, strobe_on, strobe_off, sel_rel, oe_rel, finish;

  ata_pio_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (expired)
  );

  ata_pio_fsm #(
    .SETUP_CYC   (SETUP_CYC),
    .ACTIVE_CYC  (ACTIVE_CYC),
    .HOLD_CYC    (HOLD_CYC),
    .RECOVER_CYC (RECOVER_CYC),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .expired    (expired),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .is_wr      (is_wr),
    .accept     (accept),
    .strobe_on  (strobe_on),
    .strobe_off (strobe_off),
    .sel_rel    (sel_rel),
    .oe_rel     (oe_rel),
    .finish     (finish)
  );

  ata_pio_pins #(.DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req_write   (req_write),
    .req_sel     (req_sel),
    .req_wdata   (req_wdata),
    .is_wr       (is_wr),
    .strobe_on   (strobe_on),
    .strobe_off  (strobe_off),
    .sel_rel     (sel_rel),
    .oe_rel      (oe_rel),
    .finish      (finish),
    .ata_din     (ata_din),
    .ata_sel     (ata_sel),
    .ata_iowr_n  (ata_iowr_n),
    .ata_iord_n  (ata_iord_n),
    .ata_dout    (ata_dout),
    .ata_dout_en (ata_dout_en),
    .rd_data     (rd_data),
    .busy        (busy),
    .done        (done)
  );

endmodule

// File: rtl/ata_pio_checker.sv
module ata_pio_checker #(
  parameter int SETUP_CYC  = 6,
  parameter int ACTIVE_CYC = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic [4:0] ata_sel,
  input logic       ata_iowr_n,
  input logic       ata_iord_n,
  input logic       ata_dout_en
);

  logic        strobe_low;
  logic [15:0] sel_cnt, low_cnt;

  assign strobe_low = !ata_iowr_n || !ata_iord_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_cnt <= '0;
      low_cnt <= '0;
    end else begin
      if (ata_sel == 5'b11000)  sel_cnt <= '0;
      else if (sel_cnt != '1)   sel_cnt <= sel_cnt + 16'd1;
      if (!strobe_low)          low_cnt <= '0;
      else if (low_cnt != '1)   low_cnt <= low_cnt + 16'd1;
    end
  end

  // R2: a taken request raises busy
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R3: select held the full setup time before the strobe falls
  assert_setup_count_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe_low && !$past(strobe_low)) |-> (int'(sel_cnt) >= SETUP_CYC));

  // R3: select unchanged during the strobe
  assert_sel_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe_low && $past(strobe_low)) |-> $stable(ata_sel));

  // R4: never both strobes low
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(!ata_iowr_n && !ata_iord_n));

  // R4: strobe low width
  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
    (!strobe_low && $past(strobe_low)) |-> (int'(low_cnt) == ACTIVE_CYC));

  // R5: write strobe only with drivers on and a card selected
  assert_write_drive_R5: assert property (@(posedge clk) disable iff (rst)
    !ata_iowr_n |-> (ata_dout_en && ata_sel != 5'b11000));

  // R6: read strobe never with drivers on
  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    !ata_iord_n |-> !ata_dout_en);

  // R7: select idles the cycle after strobe release
  assert_release_order_R7: assert property (@(posedge clk) disable iff (rst)
    (!strobe_low && $past(strobe_low)) |=> (ata_sel == 5'b11000));

  // R8: done is a single-cycle pulse with busy low
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind ata_pio_engine ata_pio_checker #(
  .SETUP_CYC  (SETUP_CYC),
  .ACTIVE_CYC (ACTIVE_CYC)
) u_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .busy        (busy),
  .done        (done),
  .ata_sel     (ata_sel),
  .ata_iowr_n  (ata_iowr_n),
  .ata_iord_n  (ata_iord_n),
  .ata_dout_en (ata_dout_en)
);

// File: tb/tb_ata_pio_engine.sv
`timescale 1ns/1ps
module tb_ata_pio_engine;

  localparam int DW = 16;
  localparam int S  = 6;
  localparam int A  = 12;
  localparam int H  = 6;
  localparam int RC = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [4:0]    req_sel = 5'h18;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done, ata_iowr_n, ata_iord_n, ata_dout_en;
  logic [DW-1:0] rd_data, ata_dout, ata_din;
  logic [4:0]    ata_sel;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ata_pio_engine #(
    .DATA_W(DW), .SETUP_CYC(S), .ACTIVE_CYC(A), .HOLD_CYC(H), .RECOVER_CYC(RC)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .ata_sel(ata_sel), .ata_iowr_n(ata_iowr_n),
    .ata_iord_n(ata_iord_n), .ata_dout(ata_dout), .ata_dout_en(ata_dout_en),
    .ata_din(ata_din)
  );

  // card model: fresh pattern per read, valid only while the read strobe is low
  logic [5:0] bus_idx;
  logic       prev_rd_low;
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_idx     <= '0;
      prev_rd_low <= 1'b0;
    end else begin
      prev_rd_low <= !ata_iord_n;
      if (prev_rd_low && ata_iord_n) bus_idx <= bus_idx + 6'd1;
    end
  end
  assign ata_din = ata_iord_n ? 16'h0000 : {2'b11, bus_idx, 3'b000, ata_sel};

  // behavioural reference
  bit          m_act;
  bit          m_wr;
  int          m_j;
  int          m_dn;
  logic [4:0]  m_sel;
  logic [15:0] m_wd;
  logic [15:0] m_rd;
  int          m_idx;

  always @(posedge clk) begin
    bit pre_busy;
    if (rst) begin
      m_act = 0; m_j = 0; m_dn = 0; m_rd = '0; m_idx = 0; m_wr = 0;
      m_sel = 5'h18; m_wd = '0;
    end else begin
      pre_busy = m_act && (m_j < m_dn);
      if (!pre_busy && req_valid) begin
        m_act = 1; m_j = 0; m_wr = req_write; m_sel = req_sel; m_wd = req_wdata;
        m_dn = req_write ? (S + A + 1 + H + RC) : (S + A + 1);
      end else if (m_act) begin
        if (m_j < m_dn) begin
          m_j = m_j + 1;
          if (m_j == S + A && !m_wr) begin
            m_rd  = {2'b11, 6'(m_idx), 3'b000, m_sel};
            m_idx = m_idx + 1;
          end
        end else begin
          m_act = 0;
        end
      end
    end
  end

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [4:0] e_sel;
      bit e_low, e_oe, e_busy, e_done;
      e_sel  = (m_act && m_j < S + A + 1) ? m_sel : 5'h18;
      e_low  = m_act && m_j >= S && m_j < S + A;
      e_oe   = m_act && m_wr && m_j < S + A + 1 + H;
      e_busy = m_act && m_j < m_dn;
      e_done = m_act && m_j == m_dn;
      chk("R3/R7", "sel", 32'(ata_sel), 32'(e_sel));
      chk("R4", "iowr_n", 32'(ata_iowr_n), 32'(!(e_low && m_wr)));
      chk("R4", "iord_n", 32'(ata_iord_n), 32'(!(e_low && !m_wr)));
      chk("R5/R6", "dout_en", 32'(ata_dout_en), 32'(e_oe));
      if (e_oe) chk("R5", "dout", 32'(ata_dout), 32'(m_wd));
      chk("R2/R8", "busy", 32'(busy), 32'(e_busy));
      chk("R8", "done", 32'(done), 32'(e_done));
      chk("R6/R9", "rd_data", 32'(rd_data), 32'(m_rd));
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic issue(bit wr, logic [4:0] sel, logic [15:0] wd);
    wait_idle();
    req_valid = 1; req_write = wr; req_sel = sel; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "sel", 32'(ata_sel), 32'h18);
    chk("R1", "iowr_n", 32'(ata_iowr_n), 32'h1);
    chk("R1", "iord_n", 32'(ata_iord_n), 32'h1);
    chk("R1", "dout_en", 32'(ata_dout_en), 32'h0);
    chk("R1", "busy", 32'(busy), 32'h0);
    chk("R1", "done", 32'(done), 32'h0);
    chk("R1", "rd_data", 32'(rd_data), 32'h0);
    rst = 0;
    cmp_on = 1;
    // R5 write to a task-file register, R6 reads of status and alternate status
    issue(1, 5'h13, 16'h00A7);
    issue(0, 5'h17, 16'hFFFF);
    issue(0, 5'h0E, 16'h1234);
    // R9: write after read leaves captured word
    issue(1, 5'h0E, 16'h0004);
    issue(1, 5'h16, 16'h00E5);
    // R2: conflicting request pulsed while busy is ignored
    issue(0, 5'h10, 16'h0000);
    repeat (4) @(negedge clk);
    req_valid = 1; req_write = 1; req_sel = 5'h11; req_wdata = 16'hBEEF;
    repeat (3) @(negedge clk);
    req_valid = 0;
    // R8: back-to-back requests held high through done
    wait_idle();
    req_valid = 1; req_write = 0; req_sel = 5'h12; req_wdata = '0;
    @(negedge clk);
    while (!done) @(negedge clk);
    req_write = 1; req_sel = 5'h14; req_wdata = 16'h5A5A;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
    issue(0, 5'h15, 16'h0);
    wait_idle();
    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule